// File: doc/BRIEF.md
# Prefetch Burst Serializer

This block connects a wide internal column path to a narrow external data pin group. A single command carries a start column and a direction. The block makes one internal core access per command, and that access moves a prefetch word of PREFETCH bits per pin. An internal counter then produces every column of the burst after the first. The burst length equals the prefetch factor, so the serializer register is exactly one prefetch word deep.

On a read, the block places the core word in a parallel-to-serial register. It shifts out one beat per clock with a valid strobe, in ascending column order from the start column. On a write, the block samples the data pins for one burst of beats and places each beat at its column's slot. It then commits the gathered word to the core in a single access. Any beat within the aligned block can start a burst. The column wraps inside the block, and the upper column bits stay fixed. Commands spaced exactly one burst apart produce seamless traffic.

Top module: `prefetch_burst_engine`

## Requirements
- R1: A read command accepted in cycle c drives `core_rd_en` high in cycle c, with `core_rd_col` equal to the start column with its low log2(PREFETCH) bits cleared.
- R2: For a read accepted in cycle c, `dq_out_vld` is high in cycles c+2 through c+PREFETCH+1 only, which is exactly PREFETCH beats. The core returns its word in cycle c+1.
- R3: In a core word, the column with offset j in the aligned block occupies bits [j*PINS +: PINS]. Read beats carry the slices for offsets start, start+1, and so on, taken modulo PREFETCH.
- R4: `beat_col` gives the column of every valid beat. Its low log2(PREFETCH) bits count up and wrap within the aligned block, and its upper bits equal those of the start column.
- R5: A command accepted exactly PREFETCH cycles after the previous one continues the beat stream with no idle cycle between the bursts. This holds for reads and for writes.
- R6: A command presented fewer than PREFETCH cycles after the last accepted command is ignored. It causes no core access, no beats and no write commit.
- R7: For a write accepted in cycle c, `dq_in` is sampled in cycles c+2 through c+PREFETCH+1. Beat k is stored at offset (start+k) mod PREFETCH, using the slice layout of R3.
- R8: A write accepted in cycle c pulses `core_wr_en` for one cycle in cycle c+PREFETCH+2. The pulse carries the gathered word, and `core_wr_col` holds the aligned column.
- R9: While reset is asserted and immediately after it, `dq_out_vld` and `core_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | Command present |
| cmd_wr | input | 1 | 1 = write burst, 0 = read burst |
| cmd_col | input | COL_W | Start column of the burst |
| core_rd_en | output | 1 | Core read strobe |
| core_rd_col | output | COL_W | Aligned column of the core read |
| core_rd_data | input | PINS*PREFETCH | Core read word, valid the cycle after the strobe |
| core_wr_en | output | 1 | Core write strobe |
| core_wr_col | output | COL_W | Aligned column of the core write |
| core_wr_data | output | PINS*PREFETCH | Gathered write word |
| dq_out | output | PINS | Read beat |
| dq_out_vld | output | 1 | Read beat valid |
| beat_col | output | COL_W | Column of the current read beat |
| dq_in | input | PINS | Write beat |

## Verification
The bench targets unaligned start columns, including the last offset of a block. A design that counts without wrapping would cross into the next block, and one that ignores the start offset would emit beats in plain slice order. The bench also sends commands one cycle and PREFETCH-1 cycles into a burst, where a wrong gap counter would restart the burst or cut it short. It places reads and writes exactly PREFETCH cycles apart in all mixes. Here an off-by-one in the load priority would either insert an idle beat or drop the final write beat when the next gather begins on the same edge.

// File: rtl/burst_pkg.sv
`timescale 1ns/1ps
package burst_pkg;

   // legal prefetch depths per access
   function automatic bit pf_legal(input int pf);
      return (pf == 1) || (pf == 2) || (pf == 4) || (pf == 8);
   endfunction

   // width of the in-block column offset (at least one bit)
   function automatic int off_width(input int pf);
      return (pf > 1) ? $clog2(pf) : 1;
   endfunction

endpackage

// File: rtl/burst_col_ctr.sv
`timescale 1ns/1ps
module burst_col_ctr #(
   parameter int COL_W    = 6,
   parameter int PREFETCH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [COL_W-1:0] start,
   output logic [COL_W-1:0] col
);
   localparam logic [COL_W-1:0] LOW_MASK = COL_W'(PREFETCH - 1);

   logic [COL_W-1:0] col_q;
   logic [COL_W-1:0] col_inc;

   // low bits wrap inside the aligned block, high bits never move
   always_comb begin
      col_inc = (col_q & ~LOW_MASK) | ((col_q + COL_W'(1)) & LOW_MASK);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q <= '0;
      end else if (load) begin
         col_q <= start;
      end else if (step) begin
         col_q <= col_inc;
      end
   end

   assign col = col_q;
endmodule

// File: rtl/burst_piso.sv
`timescale 1ns/1ps
module burst_piso #(
   parameter int PINS     = 4,
   parameter int PREFETCH = 4
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  load,
   input  logic [PINS*PREFETCH-1:0]              word,
   input  logic [burst_pkg::off_width(PREFETCH)-1:0] off,
   output logic [PINS-1:0]                       beat,
   output logic                                  vld
);
   localparam int WORD_W = PINS * PREFETCH;
   localparam int CNT_W  = $clog2(PREFETCH + 1);

   logic [WORD_W-1:0] rot;
   logic [WORD_W-1:0] sr_q;
   logic [CNT_W-1:0]  left_q;

   // rotate so that the start column's slice leaves first
   always_comb begin
      rot = '0;
      for (int j = 0; j < PREFETCH; j++) begin
         rot[j*PINS +: PINS] = word[((j + int'(off)) % PREFETCH)*PINS +: PINS];
      end
   end

   generate
      if (PREFETCH == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sr_q   <= '0;
               left_q <= '0;
            end else if (load) begin
               sr_q   <= rot;
               left_q <= CNT_W'(1);
            end else begin
               left_q <= '0;
            end
         end
      end else begin : g_shift
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sr_q   <= '0;
               left_q <= '0;
            end else if (load) begin
               sr_q   <= rot;
               left_q <= CNT_W'(PREFETCH);
            end else if (left_q != '0) begin
               sr_q   <= sr_q >> PINS;
               left_q <= left_q - CNT_W'(1);
            end
         end
      end
   endgenerate

   assign beat = sr_q[PINS-1:0];
   assign vld  = (left_q != '0);
endmodule

// File: rtl/burst_sipo.sv
`timescale 1ns/1ps
module burst_sipo #(
   parameter int PINS     = 4,
   parameter int PREFETCH = 4,
   parameter int COL_W    = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [COL_W-1:0]         start,
   input  logic [PINS-1:0]          din,
   output logic                     wr_en,
   output logic [COL_W-1:0]         wr_col,
   output logic [PINS*PREFETCH-1:0] wr_data
);
   localparam int WORD_W = PINS * PREFETCH;
   localparam int CNT_W  = $clog2(PREFETCH + 1);
   localparam logic [COL_W-1:0] LOW_MASK = COL_W'(PREFETCH - 1);

   logic [CNT_W-1:0]  left_q;
   logic [WORD_W-1:0] gather_q;
   logic [WORD_W-1:0] merged;
   logic [COL_W-1:0]  col;
   logic              active;
   logic              last;

   assign active = (left_q != '0);
   assign last   = (left_q == CNT_W'(1));

   burst_col_ctr #(.COL_W(COL_W), .PREFETCH(PREFETCH)) u_col (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .step  (active),
      .start (start),
      .col   (col)
   );

   // drop the current beat into the slot of its column
   always_comb begin
      merged = gather_q;
      merged[int'(col & LOW_MASK)*PINS +: PINS] = din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q   <= '0;
         gather_q <= '0;
         wr_en    <= 1'b0;
         wr_col   <= '0;
         wr_data  <= '0;
      end else begin
         wr_en <= active && last;
         if (active) begin
            gather_q <= merged;
         end
         if (active && last) begin
            wr_data <= merged;
            wr_col  <= col & ~LOW_MASK;
         end
         if (load) begin
            left_q <= CNT_W'(PREFETCH);
         end else if (active) begin
            left_q <= left_q - CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/prefetch_burst_engine.sv
`timescale 1ns/1ps
module prefetch_burst_engine #(
   parameter int PINS     = 4,
   parameter int PREFETCH = 4,
   parameter int COL_W    = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cmd_vld,
   input  logic                     cmd_wr,
   input  logic [COL_W-1:0]         cmd_col,
   output logic                     core_rd_en,
   output logic [COL_W-1:0]         core_rd_col,
   input  logic [PINS*PREFETCH-1:0] core_rd_data,
   output logic                     core_wr_en,
   output logic [COL_W-1:0]         core_wr_col,
   output logic [PINS*PREFETCH-1:0] core_wr_data,
   output logic [PINS-1:0]          dq_out,
   output logic                     dq_out_vld,
   output logic [COL_W-1:0]         beat_col,
   input  logic [PINS-1:0]          dq_in
);
   localparam int OFF_W = burst_pkg::off_width(PREFETCH);
   localparam int GAP_W = OFF_W;
   localparam logic [COL_W-1:0] LOW_MASK = COL_W'(PREFETCH - 1);

   generate
      if (!burst_pkg::pf_legal(PREFETCH)) begin : g_bad_pf
         $error("PREFETCH must be 1, 2, 4 or 8");
      end
      if (COL_W <= OFF_W) begin : g_bad_col
         $error("COL_W must exceed the in-block offset width");
      end
      if (PINS < 1) begin : g_bad_pins
         $error("PINS must be at least 1");
      end
   endgenerate

   logic [GAP_W-1:0] gap_q;
   logic             accept;
   logic             rd_pend_q;
   logic             wr_pend_q;
   logic [COL_W-1:0] start_q;

   // one command per burst slot; early commands are dropped
   assign accept = cmd_vld && (gap_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q     <= '0;
         rd_pend_q <= 1'b0;
         wr_pend_q <= 1'b0;
         start_q   <= '0;
      end else begin
         if (accept) begin
            gap_q <= GAP_W'(PREFETCH - 1);
         end else if (gap_q != '0) begin
            gap_q <= gap_q - GAP_W'(1);
         end
         rd_pend_q <= accept && !cmd_wr;
         wr_pend_q <= accept && cmd_wr;
         if (accept) begin
            start_q <= cmd_col;
         end
      end
   end

   assign core_rd_en  = accept && !cmd_wr;
   assign core_rd_col = cmd_col & ~LOW_MASK;

   burst_piso #(.PINS(PINS), .PREFETCH(PREFETCH)) u_piso (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (rd_pend_q),
      .word  (core_rd_data),
      .off   (start_q[OFF_W-1:0]),
      .beat  (dq_out),
      .vld   (dq_out_vld)
   );

   burst_col_ctr #(.COL_W(COL_W), .PREFETCH(PREFETCH)) u_rd_col (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (rd_pend_q),
      .step  (dq_out_vld),
      .start (start_q),
      .col   (beat_col)
   );

   burst_sipo #(.PINS(PINS), .PREFETCH(PREFETCH), .COL_W(COL_W)) u_sipo (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (wr_pend_q),
      .start   (start_q),
      .din     (dq_in),
      .wr_en   (core_wr_en),
      .wr_col  (core_wr_col),
      .wr_data (core_wr_data)
   );
endmodule

// File: rtl/burst_engine_chk.sv
`timescale 1ns/1ps
module burst_engine_chk #(
   parameter int PINS     = 4,
   parameter int PREFETCH = 4,
   parameter int COL_W    = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             core_rd_en,
   input logic [COL_W-1:0] core_rd_col,
   input logic             core_wr_en,
   input logic [COL_W-1:0] core_wr_col,
   input logic             dq_out_vld,
   input logic [COL_W-1:0] beat_col
);
   localparam logic [COL_W-1:0] LOW_MASK = COL_W'(PREFETCH - 1);

   int rd_since;
   int wr_since;
   int idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_since <= PREFETCH;
         wr_since <= PREFETCH;
         idx      <= 0;
      end else begin
         if (core_rd_en) rd_since <= 1;
         else if (rd_since < PREFETCH) rd_since <= rd_since + 1;
         if (core_wr_en) wr_since <= 1;
         else if (wr_since < PREFETCH) wr_since <= wr_since + 1;
         if (dq_out_vld) idx <= (idx + 1) % PREFETCH;
      end
   end

   // R1
   rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_rd_en |-> ((core_rd_col & LOW_MASK) == '0));

   // R2
   rd_to_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_rd_en |-> ##2 dq_out_vld);

   // R2
   burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dq_out_vld) |-> (idx == 0));

   // R4
   beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_out_vld && idx != 0) |->
         (((beat_col & LOW_MASK) == (($past(beat_col) + COL_W'(1)) & LOW_MASK)) &&
          ((beat_col & ~LOW_MASK) == ($past(beat_col) & ~LOW_MASK))));

   // R6
   rd_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_rd_en |-> (rd_since >= PREFETCH));

   // R8
   wr_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_wr_en |-> (wr_since >= PREFETCH));

   // R8
   wr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_wr_en |-> ((core_wr_col & LOW_MASK) == '0));
endmodule

bind prefetch_burst_engine burst_engine_chk #(
   .PINS(PINS), .PREFETCH(PREFETCH), .COL_W(COL_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .core_rd_en  (core_rd_en),
   .core_rd_col (core_rd_col),
   .core_wr_en  (core_wr_en),
   .core_wr_col (core_wr_col),
   .dq_out_vld  (dq_out_vld),
   .beat_col    (beat_col)
);

// File: tb/tb_prefetch_burst_engine.sv
`timescale 1ns/1ps
module tb_prefetch_burst_engine;
   localparam int PINS     = 4;
   localparam int PREFETCH = 4;
   localparam int COL_W    = 6;
   localparam int WORD_W   = PINS * PREFETCH;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_vld = 1'b0;
   logic              cmd_wr = 1'b0;
   logic [COL_W-1:0]  cmd_col = '0;
   logic              core_rd_en;
   logic [COL_W-1:0]  core_rd_col;
   logic [WORD_W-1:0] core_rd_data = '0;
   logic              core_wr_en;
   logic [COL_W-1:0]  core_wr_col;
   logic [WORD_W-1:0] core_wr_data;
   logic [PINS-1:0]   dq_out;
   logic              dq_out_vld;
   logic [COL_W-1:0]  beat_col;
   logic [PINS-1:0]   dq_in = '0;

   always #4 clk = ~clk;

   prefetch_burst_engine #(.PINS(PINS), .PREFETCH(PREFETCH), .COL_W(COL_W)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .cmd_col(cmd_col),
      .core_rd_en(core_rd_en), .core_rd_col(core_rd_col), .core_rd_data(core_rd_data),
      .core_wr_en(core_wr_en), .core_wr_col(core_wr_col), .core_wr_data(core_wr_data),
      .dq_out(dq_out), .dq_out_vld(dq_out_vld), .beat_col(beat_col), .dq_in(dq_in)
   );

   function automatic logic [WORD_W-1:0] pat(input int addr);
      logic [63:0] h;
      h = 64'(addr + 1) * 64'h9E37_79B9_7F4A_7C15;
      return WORD_W'(h ^ (h >> 29));
   endfunction

   function automatic logic [PINS-1:0] din(input int cy);
      return PINS'((cy * 37 + 11) ^ (cy >> 2));
   endfunction

   // behavioural core: word arrives the cycle after the strobe
   always @(posedge clk) begin
      if (core_rd_en) core_rd_data <= pat(int'(core_rd_col));
   end

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int next_ok = 0;
   bit done   = 1'b0;
   bit b2b_phase = 1'b0;

   bit                e_rden [int];
   logic [COL_W-1:0]  e_rdcol[int];
   bit                e_vld  [int];
   logic [PINS-1:0]   e_dq   [int];
   logic [COL_W-1:0]  e_col  [int];
   bit                e_wren [int];
   logic [COL_W-1:0]  e_wrcol[int];
   logic [WORD_W-1:0] e_wrdat[int];
   bit                ignored[int];

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
      end
   endtask

   task automatic plan_cmd(input bit w, input int s);
      int base;
      logic [WORD_W-1:0] word;
      base = s & ~(PREFETCH - 1);
      word = '0;
      if (!w) begin
         e_rden[cyc]  = 1'b1;
         e_rdcol[cyc] = COL_W'(base);
      end
      for (int k = 0; k < PREFETCH; k++) begin
         int off;
         int cy;
         off = (s + k) % PREFETCH;
         cy  = cyc + 2 + k;
         if (!w) begin
            logic [WORD_W-1:0] pw;
            pw = pat(base);
            e_vld[cy] = 1'b1;
            e_dq[cy]  = pw[off*PINS +: PINS];
            e_col[cy] = COL_W'(base + off);
         end else begin
            word[off*PINS +: PINS] = din(cy);
         end
      end
      if (w) begin
         e_wren[cyc + PREFETCH + 2]  = 1'b1;
         e_wrcol[cyc + PREFETCH + 2] = COL_W'(base);
         e_wrdat[cyc + PREFETCH + 2] = word;
      end
   endtask

   task automatic cycle(input bit v, input bit w, input int s);
      bit xr;
      bit xv;
      bit xw;
      @(negedge clk);
      cmd_vld = v;
      cmd_wr  = w;
      cmd_col = COL_W'(s);
      dq_in   = din(cyc);
      if (v) begin
         if (cyc >= next_ok) begin
            next_ok = cyc + PREFETCH;
            plan_cmd(w, s);
         end else begin
            ignored[cyc] = 1'b1;
         end
      end
      #1;
      xr = e_rden.exists(cyc);
      if (ignored.exists(cyc))
         chk(core_rd_en == xr, "R6", "ignored command core read", core_rd_en, xr);
      else
         chk(core_rd_en == xr, "R1", "core read strobe", core_rd_en, xr);
      if (xr) chk(core_rd_col == e_rdcol[cyc], "R1", "core read column", core_rd_col, e_rdcol[cyc]);
      xv = e_vld.exists(cyc);
      if (b2b_phase)
         chk(dq_out_vld == xv, "R5", "seamless beat valid", dq_out_vld, xv);
      else
         chk(dq_out_vld == xv, "R2", "beat valid", dq_out_vld, xv);
      if (xv) begin
         chk(dq_out == e_dq[cyc], "R3", "beat data", dq_out, e_dq[cyc]);
         chk(beat_col == e_col[cyc], "R4", "beat column", beat_col, e_col[cyc]);
      end
      xw = e_wren.exists(cyc);
      chk(core_wr_en == xw, "R8", "core write strobe", core_wr_en, xw);
      if (xw) begin
         chk(core_wr_col == e_wrcol[cyc], "R8", "core write column", core_wr_col, e_wrcol[cyc]);
         chk(core_wr_data == e_wrdat[cyc], "R7", "gathered write word", core_wr_data, e_wrdat[cyc]);
      end
      cyc++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 0);
   endtask

   initial begin
      #800000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(dq_out_vld == 1'b0, "R9", "valid in reset", dq_out_vld, 0);
      chk(core_wr_en == 1'b0, "R9", "write strobe in reset", core_wr_en, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dq_out_vld == 1'b0 && core_wr_en == 1'b0, "R9", "outputs after reset",
          {dq_out_vld, core_wr_en}, 0);

      // aligned, unaligned, last offset
      cycle(1'b1, 1'b0, 0);  idle(PREFETCH + 3);
      cycle(1'b1, 1'b0, 7);  idle(PREFETCH + 3);
      cycle(1'b1, 1'b0, 45); idle(PREFETCH + 3);

      // early commands dropped (R6), then one at the boundary (R5)
      b2b_phase = 1'b1;
      cycle(1'b1, 1'b0, 13);
      cycle(1'b1, 1'b0, 20);
      for (int i = 2; i < PREFETCH; i++) cycle(1'b1, 1'b1, 33);
      cycle(1'b1, 1'b0, 50);
      idle(PREFETCH - 1);
      cycle(1'b1, 1'b1, 2);
      idle(PREFETCH - 1);
      cycle(1'b1, 1'b1, 63);
      idle(PREFETCH - 1);
      cycle(1'b1, 1'b0, 30);
      idle(PREFETCH + 4);
      b2b_phase = 1'b0;

      // mixed traffic with varied spacing
      for (int i = 0; i < 3000; i++) begin
         bit v;
         v = ($urandom % 3) != 0;
         cycle(v, 1'($urandom % 2), int'($urandom % (1 << COL_W)));
      end
      idle(PREFETCH + 6);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule